// File: doc/BRIEF.md
# Two-Wheel Speed Capture with Slip Ratio

This block measures how fast two wheels are turning. One wheel rolls freely and serves as the vehicle speed reference; the other is the wheel being braked. Each wheel sensor delivers a squared-up pulse train with 50 cycles per revolution. For every channel the block counts ticks of a shared, programmable time base between successive rising edges. The latest count is held as that channel's period, and a larger period means a slower wheel.

A wheel that stops or turns very slowly makes the period counter saturate. The channel then reports zero and drops its valid flag. Whenever a new period is latched while both channels are valid, a small sequential divider forms the slip ratio 1 - T_ref/T_brk as an unsigned Q0.16 fraction. It publishes the result together with a one-cycle strobe. The anti-skid loop downstream treats this ratio as its controlled quantity.

Top module: `wheel_slip_capture`

## Requirements
- R1: Each sensor input is synchronized through two flops. Only its low-to-high transitions delimit a period, so a falling edge neither ends nor restarts a measurement.
- R2: After reset, or after a timeout, the first rising edge on a channel only arms that channel. Its valid flag stays 0 until the second rising edge, which latches the first period.
- R3: The latched period equals the number of time-base ticks from one rising edge to the next. With `prescale_div` = 0, that is the edge spacing in clock cycles.
- R4: Both channels share one time base that ticks once every `prescale_div`+1 clock cycles. An edge spacing of K*(`prescale_div`+1) clocks therefore latches exactly K.
- R5: If a tick arrives while a channel's counter is all ones and no rising edge comes with it, the channel times out. Its period becomes 0, its valid flag becomes 0, and it re-arms as in R2.
- R6: While a channel's valid flag is 0, its period output reads 0.
- R7: The slip output equals floor((T_brk - T_ref) * 65536 / T_brk) when T_brk > T_ref, and 0 when T_brk <= T_ref. The braked wheel is then turning as fast as the reference wheel or faster.
- R8: `slip_stb` is high for exactly one cycle with each new slip value. `slip` changes only in a cycle where `slip_stb` is high.
- R9: The two channels are independent, so a stalled braked wheel leaves the reference period unchanged.
- R10: No slip result is published unless both channels were valid in the cycle before the strobe. While either channel is invalid, `slip_stb` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Squared sensor signal of the free-rolling reference wheel (asynchronous) |
| brk_in | input | 1 | Squared sensor signal of the braked wheel (asynchronous) |
| prescale_div | input | PRE_W | Time-base divider; one tick every prescale_div+1 clocks |
| ref_period | output | CNT_W | Latched tick count of the reference wheel, 0 when invalid |
| ref_valid | output | 1 | Reference period is valid |
| brk_period | output | CNT_W | Latched tick count of the braked wheel, 0 when invalid |
| brk_valid | output | 1 | Braked-wheel period is valid |
| slip | output | SLIP_W | Slip ratio, unsigned Q0.16 |
| slip_stb | output | 1 | One-cycle strobe marking a new slip value |

## Verification
The hardest state to reach from the ports is the timeout. It needs one channel to go silent for a full counter range of ticks while the other channel keeps measuring, followed by a clean re-arm. The bench stops toggling the braked input for more than 65,536 cycles at a prescale of 0 while the reference keeps running. It then confirms that the stalled channel reads zero, that the reference period is undisturbed, and that no slip strobe appears. Finally it restarts the input and checks that only the second rising edge restores validity. A separate run with a nonzero prescale confirms that the period counts time-base ticks rather than clocks.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
    localparam int DEF_CNT_W  = 16;
    localparam int DEF_PRE_W  = 8;
    localparam int DEF_SLIP_W = 16;
    localparam int NUM_CH     = 2;
    localparam int CH_REF     = 0;
    localparam int CH_BRK     = 1;

    // Per-channel measurement state
    typedef enum logic {
        CH_IDLE  = 1'b0,   // waiting for an arming edge
        CH_ARMED = 1'b1    // counting ticks since the last rising edge
    } ch_state_e;

    // Slip divider state
    typedef enum logic {
        DV_IDLE = 1'b0,
        DV_RUN  = 1'b1
    } dv_state_e;
endpackage

// File: rtl/wsc_tick_gen.sv
module wsc_tick_gen #(
    parameter int PRE_W = wsc_pkg::DEF_PRE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PRE_W-1:0] prescale_div,
    output logic             tick
);
    logic [PRE_W-1:0] div_cnt;

    assign tick = (div_cnt >= prescale_div);

    always_ff @(posedge clk) begin
        if (rst)       div_cnt <= '0;
        else if (tick) div_cnt <= '0;
        else           div_cnt <= div_cnt + 1'b1;
    end
endmodule

// File: rtl/wsc_channel.sv
module wsc_channel
    import wsc_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             sense_in,
    output logic [CNT_W-1:0] period,
    output logic             valid,
    output logic             cap_stb
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [2:0]       sync_q;   // two synchronizer stages plus edge history
    logic             rise;
    ch_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] span_sat;

    assign rise     = sync_q[1] & ~sync_q[2];
    // the tick in the edge cycle belongs to the closing interval
    assign span     = {1'b0, cnt} + {{CNT_W{1'b0}}, tick};
    assign span_sat = span[CNT_W] ? CNT_MAX : span[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[1:0], sense_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= CH_IDLE;
            cnt     <= '0;
            period  <= '0;
            valid   <= 1'b0;
            cap_stb <= 1'b0;
        end else begin
            cap_stb <= 1'b0;
            if (rise) begin
                cnt   <= '0;
                state <= CH_ARMED;
                if (state == CH_ARMED) begin
                    period  <= span_sat;
                    valid   <= 1'b1;
                    cap_stb <= 1'b1;
                end
            end else if (state == CH_ARMED && tick) begin
                if (cnt == CNT_MAX) begin
                    // stalled wheel: report zero speed and re-arm
                    state  <= CH_IDLE;
                    cnt    <= '0;
                    period <= '0;
                    valid  <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/wsc_slip_div.sv
module wsc_slip_div
    import wsc_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int SLIP_W = DEF_SLIP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  ref_period,
    input  logic [CNT_W-1:0]  brk_period,
    input  logic              ref_valid,
    input  logic              brk_valid,
    input  logic              new_cap,
    output logic [SLIP_W-1:0] slip,
    output logic              slip_stb
);
    localparam int STEP_W = $clog2(SLIP_W + 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SLIP_W - 1);

    dv_state_e         state;
    logic              pending;
    logic              sat;
    logic [CNT_W:0]    rem;
    logic [CNT_W-1:0]  dvs;
    logic [SLIP_W-1:0] quo;
    logic [STEP_W-1:0] step;
    logic              both;
    logic [CNT_W:0]    shifted;
    logic              q_bit;
    logic [CNT_W:0]    rem_next;

    assign both     = ref_valid & brk_valid;
    assign shifted  = {rem[CNT_W-1:0], 1'b0};
    assign q_bit    = (shifted >= {1'b0, dvs});
    assign rem_next = q_bit ? (shifted - {1'b0, dvs}) : shifted;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= DV_IDLE;
            pending  <= 1'b0;
            sat      <= 1'b0;
            rem      <= '0;
            dvs      <= '0;
            quo      <= '0;
            step     <= '0;
            slip     <= '0;
            slip_stb <= 1'b0;
        end else begin
            slip_stb <= 1'b0;
            pending  <= both & (pending | new_cap);
            case (state)
                DV_IDLE: begin
                    if (both && (pending || new_cap)) begin
                        state   <= DV_RUN;
                        pending <= 1'b0;
                        dvs     <= brk_period;
                        step    <= '0;
                        quo     <= '0;
                        // a reference period of zero means the ratio rounds to one
                        sat     <= (ref_period == '0) && (brk_period != '0);
                        rem     <= (brk_period > ref_period) ?
                                   {1'b0, brk_period - ref_period} : '0;
                    end
                end
                DV_RUN: begin
                    if (!both) begin
                        state   <= DV_IDLE;
                        pending <= 1'b0;
                    end else begin
                        rem  <= rem_next;
                        quo  <= {quo[SLIP_W-2:0], q_bit};
                        step <= step + 1'b1;
                        if (step == LAST_STEP) begin
                            state    <= DV_IDLE;
                            slip_stb <= 1'b1;
                            slip     <= sat ? '1 : {quo[SLIP_W-2:0], q_bit};
                        end
                    end
                end
                default: state <= DV_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wheel_slip_capture.sv
module wheel_slip_capture
    import wsc_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int PRE_W  = DEF_PRE_W,
    parameter int SLIP_W = DEF_SLIP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_in,
    input  logic              brk_in,
    input  logic [PRE_W-1:0]  prescale_div,
    output logic [CNT_W-1:0]  ref_period,
    output logic              ref_valid,
    output logic [CNT_W-1:0]  brk_period,
    output logic              brk_valid,
    output logic [SLIP_W-1:0] slip,
    output logic              slip_stb
);
    logic                tick;
    logic [NUM_CH-1:0]   sense;
    logic [CNT_W-1:0]    ch_period [NUM_CH];
    logic [NUM_CH-1:0]   ch_valid;
    logic [NUM_CH-1:0]   ch_cap;

    assign sense[CH_REF] = ref_in;
    assign sense[CH_BRK] = brk_in;

    wsc_tick_gen #(.PRE_W(PRE_W)) u_tick (
        .clk          (clk),
        .rst          (rst),
        .prescale_div (prescale_div),
        .tick         (tick)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        wsc_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .sense_in (sense[g]),
            .period   (ch_period[g]),
            .valid    (ch_valid[g]),
            .cap_stb  (ch_cap[g])
        );
    end

    assign ref_period = ch_period[CH_REF];
    assign brk_period = ch_period[CH_BRK];
    assign ref_valid  = ch_valid[CH_REF];
    assign brk_valid  = ch_valid[CH_BRK];

    wsc_slip_div #(.CNT_W(CNT_W), .SLIP_W(SLIP_W)) u_div (
        .clk        (clk),
        .rst        (rst),
        .ref_period (ref_period),
        .brk_period (brk_period),
        .ref_valid  (ref_valid),
        .brk_valid  (brk_valid),
        .new_cap    (|ch_cap),
        .slip       (slip),
        .slip_stb   (slip_stb)
    );
endmodule

// File: rtl/wheel_slip_capture_chk.sv
module wheel_slip_capture_chk #(
    parameter int CNT_W  = 16,
    parameter int SLIP_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  ref_period,
    input logic              ref_valid,
    input logic [CNT_W-1:0]  brk_period,
    input logic              brk_valid,
    input logic [SLIP_W-1:0] slip,
    input logic              slip_stb
);
    AST_REF_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
        !ref_valid |-> ref_period == '0);                                     // R6
    AST_BRK_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
        !brk_valid |-> brk_period == '0);                                     // R6
    AST_SLIP_HELD: assert property (@(posedge clk) disable iff (rst)
        (slip != $past(slip)) |-> slip_stb);                                  // R8
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        slip_stb |=> !slip_stb);                                              // R8
    AST_STB_BOTH_VALID: assert property (@(posedge clk) disable iff (rst)
        slip_stb |-> ($past(ref_valid) && $past(brk_valid)));                 // R10
endmodule

bind wheel_slip_capture wheel_slip_capture_chk #(
    .CNT_W  (CNT_W),
    .SLIP_W (SLIP_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ref_period (ref_period),
    .ref_valid  (ref_valid),
    .brk_period (brk_period),
    .brk_valid  (brk_valid),
    .slip       (slip),
    .slip_stb   (slip_stb)
);

// File: tb/wheel_slip_capture_tb.sv
`timescale 1ns/1ps
module wheel_slip_capture_tb;
    localparam int CNT_W  = 16;
    localparam int PRE_W  = 8;
    localparam int SLIP_W = 16;
    localparam int NVEC   = 6;
    // half periods in clocks: {reference, braked}
    localparam int VEC [NVEC][2] = '{
        '{50, 50}, '{50, 60}, '{40, 100}, '{100, 40}, '{25, 200}, '{30, 31}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ref_in = 1'b0;
    logic              brk_in = 1'b0;
    logic [PRE_W-1:0]  prescale_div = '0;
    logic [CNT_W-1:0]  ref_period;
    logic              ref_valid;
    logic [CNT_W-1:0]  brk_period;
    logic              brk_valid;
    logic [SLIP_W-1:0] slip;
    logic              slip_stb;

    int  n_chk = 0;
    int  n_bad = 0;
    int  hp_ref = 50;
    int  hp_brk = 50;
    bit  run_ref = 0;
    bit  run_brk = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    wheel_slip_capture #(.CNT_W(CNT_W), .PRE_W(PRE_W), .SLIP_W(SLIP_W)) u_dut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .brk_in(brk_in),
        .prescale_div(prescale_div), .ref_period(ref_period), .ref_valid(ref_valid),
        .brk_period(brk_period), .brk_valid(brk_valid), .slip(slip), .slip_stb(slip_stb)
    );

    always begin : drv_ref
        if (run_ref) begin
            repeat (hp_ref) @(posedge clk);
            #1 ref_in = ~ref_in;
        end else @(posedge clk);
    end

    always begin : drv_brk
        if (run_brk) begin
            repeat (hp_brk) @(posedge clk);
            #1 brk_in = ~brk_in;
        end else @(posedge clk);
    end

    function automatic longint slip_model(input longint tr, input longint tb);
        if (tb <= tr) return 0;
        return ((tb - tr) * 65536) / tb;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_stb(output bit seen);
        seen = 0;
        for (int i = 0; i < 4000 && !seen; i++) begin
            @(negedge clk);
            if (slip_stb) seen = 1;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin : main
        bit seen;
        int strobes;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R2 reset ref_valid", ref_valid, 0);
        chk("R2 reset brk_valid", brk_valid, 0);
        chk("R6 reset ref_period", ref_period, 0);
        chk("R6 reset brk_period", brk_period, 0);
        chk("R8 reset slip_stb", slip_stb, 0);

        // table: full period = 2*half period, only rising edges count (R1, R3, R7)
        run_ref = 1;
        run_brk = 1;
        for (int v = 0; v < NVEC; v++) begin
            hp_ref = VEC[v][0];
            hp_brk = VEC[v][1];
            repeat (8 * ((hp_ref > hp_brk) ? hp_ref : hp_brk) + 50) @(posedge clk);
            @(negedge clk);
            chk("R1 R3 ref_period", ref_period, 2 * hp_ref);
            chk("R1 R3 brk_period", brk_period, 2 * hp_brk);
            wait_stb(seen);
            chk("R8 slip_stb seen", seen, 1);
            chk("R7 slip value", slip, slip_model(2 * hp_ref, 2 * hp_brk));
        end

        // R4: prescale 3 -> one tick per 4 clocks
        prescale_div = 8'd3;
        hp_ref = 40;
        hp_brk = 60;
        repeat (1100) @(posedge clk);
        @(negedge clk);
        chk("R4 ref_period ticks", ref_period, 20);
        chk("R4 brk_period ticks", brk_period, 30);
        wait_stb(seen);
        chk("R4 R7 slip", slip, slip_model(20, 30));
        prescale_div = '0;
        hp_ref = 50;
        hp_brk = 60;
        repeat (1000) @(posedge clk);

        // R5 timeout on the braked channel while reference keeps running
        run_brk = 0;
        repeat (200) @(posedge clk);
        #1 brk_in = 1'b0;
        repeat (67000) @(posedge clk);
        @(negedge clk);
        chk("R5 brk_valid after stall", brk_valid, 0);
        chk("R5 brk_period after stall", brk_period, 0);
        chk("R9 ref_valid during stall", ref_valid, 1);
        chk("R9 ref_period during stall", ref_period, 100);
        strobes = 0;
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (slip_stb) strobes++;
        end
        chk("R10 no slip_stb while invalid", strobes, 0);

        // R2: re-arm, first rise only arms, second rise latches
        @(posedge clk);
        #1 run_brk = 1;
        repeat (150) @(posedge clk);
        @(negedge clk);
        chk("R2 valid after first edge", brk_valid, 0);
        repeat (110) @(posedge clk);
        @(negedge clk);
        chk("R2 valid after second edge", brk_valid, 1);
        chk("R2 R3 period after re-arm", brk_period, 120);
        wait_stb(seen);
        chk("R8 R10 slip resumes", seen, 1);
        chk("R7 slip after re-arm", slip, slip_model(100, 120));

        finish_run();
    end
endmodule